// File: doc/BRIEF.md
# Topology-Aware QoS Route Selector

This block picks a route for a packet crossing a two-dimensional grid of network nodes. Each node belongs to a virtual machine, recorded as a small VM number. Some whole columns of the grid are shared regions, and quality of service is enforced only inside them. The rule is that a packet may change dimension only at a node owned by its own source VM or by the VM of its destination node. A detour through a shared column is always safe, because any node reaches such a column in one hop along its own row.

A route request carries the source and destination coordinates and the source VM number, and is presented on a valid/ready handshake. The block reads its node-to-VM table and its per-column shared flags, then picks one of the following routes, in this order:

- no turn, when source and destination share a row or a column;
- an X-then-Y turn;
- a Y-then-X turn;
- a detour through the cheapest shared column;
- a "no route" verdict, when none of the above is possible.

The result is registered and held until the consumer takes it. The table is loaded through a plain address/data/write-enable port.

Top module: `qos_route_sel`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every node's VM number is 0 and no column is shared.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its result shows on `rsp_valid` and the result fields from the next cycle on. The result stays unchanged while `rsp_ready` is 0. `req_ready` equals `!rsp_valid || rsp_ready`.
- R3: If the source and destination share a column (x equal) or a row (y equal), `rsp_kind` is 0 (straight). No VM check is made, and the turn and waypoint fields are 0.
- R4: Otherwise, the X-then-Y turn node is (dst_x, src_y). If its VM equals the request VM or the destination node's VM, `rsp_kind` is 1 and the turn output is that node.
- R5: If the X-then-Y turn is illegal and the Y-then-X turn node (src_x, dst_y) passes the same test, `rsp_kind` is 2 and the turn output is (src_x, dst_y).
- R6: If both turns are illegal and at least one column is shared, the block picks column c so that |src_x-c| + |c-dst_x| is smallest, taking the lowest c on a tie. It then gives `rsp_kind` 3, `rsp_way_valid` 1, waypoint (c, src_y) and turn (c, dst_y).
- R7: If both turns are illegal and no column is shared, `rsp_kind` is 4 (no route), and the turn and waypoint fields are 0.
- R8: A cycle with `cfg_we`=1 and `cfg_col_sel`=0 writes `cfg_vm` to node index y*GRID_X+x, given on `cfg_addr`. A cycle with `cfg_col_sel`=1 writes `cfg_shared` to the shared flag of the column in the low bits of `cfg_addr`. A request accepted in a later cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_col_sel | input | 1 | 1 = write a column shared flag, 0 = write a node VM number |
| cfg_addr | input | log2(GRID_X*GRID_Y) | Node index, or column number in the low bits |
| cfg_vm | input | VM_W | VM number to store |
| cfg_shared | input | 1 | Shared flag to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_src_x | input | log2(GRID_X) | Source column |
| req_src_y | input | log2(GRID_Y) | Source row |
| req_dst_x | input | log2(GRID_X) | Destination column |
| req_dst_y | input | log2(GRID_Y) | Destination row |
| req_vm | input | VM_W | VM of the packet source |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_kind | output | 3 | 0 straight, 1 X-then-Y, 2 Y-then-X, 3 detour, 4 no route |
| rsp_turn_x | output | log2(GRID_X) | Turn node column |
| rsp_turn_y | output | log2(GRID_Y) | Turn node row |
| rsp_way_valid | output | 1 | A shared-column waypoint is given |
| rsp_way_x | output | log2(GRID_X) | Waypoint column |
| rsp_way_y | output | log2(GRID_Y) | Waypoint row |

## Verification
The bench builds the block with its defaults: a 16 by 16 grid and 4-bit VM numbers. With 16 VM values spread at random over the nodes, most corner turns become illegal. That brings detours, and tied detour costs between far-apart shared columns, within reach of random traffic. Phases with no shared column, and with shared columns only at both die edges, reach the no-route verdict and the lowest-index tie rule. Random consumer backpressure exercises holding the result.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;
    typedef enum logic [2:0] {
        RK_STRAIGHT = 3'd0,
        RK_XY       = 3'd1,
        RK_YX       = 3'd2,
        RK_DETOUR   = 3'd3,
        RK_NONE     = 3'd4
    } route_kind_e;
endpackage

// File: rtl/rsv_vm_table.sv
module rsv_vm_table #(
    parameter int GRID_X = 16,
    parameter int GRID_Y = 16,
    parameter int VM_W   = 4,
    localparam int NODES = GRID_X * GRID_Y,
    localparam int NW    = $clog2(NODES),
    localparam int XW    = $clog2(GRID_X)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              col_sel,
    input  logic [NW-1:0]     addr,
    input  logic [VM_W-1:0]   vm_in,
    input  logic              shared_in,
    input  logic [NW-1:0]     rd_a,
    input  logic [NW-1:0]     rd_b,
    input  logic [NW-1:0]     rd_c,
    output logic [VM_W-1:0]   vm_a,
    output logic [VM_W-1:0]   vm_b,
    output logic [VM_W-1:0]   vm_c,
    output logic [GRID_X-1:0] shared_cols
);
    typedef struct packed {
        logic [NODES-1:0][VM_W-1:0] vm;
        logic [GRID_X-1:0]          sh;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (we) begin
            if (col_sel) t_d.sh[addr[XW-1:0]] = shared_in;
            else         t_d.vm[addr]         = vm_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign vm_a        = t_q.vm[rd_a];
    assign vm_b        = t_q.vm[rd_b];
    assign vm_c        = t_q.vm[rd_c];
    assign shared_cols = t_q.sh;

    // R8: node and column writes land in the table one cycle later
    p_node_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !col_sel) |=> (t_q.vm[$past(addr)] == $past(vm_in)));
    p_col_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && col_sel) |=> (t_q.sh[$past(addr[XW-1:0])] == $past(shared_in)));
endmodule

// File: rtl/rsv_turn_legal.sv
module rsv_turn_legal #(
    parameter int VM_W = 4
) (
    input  logic [VM_W-1:0] node_vm,
    input  logic [VM_W-1:0] src_vm,
    input  logic [VM_W-1:0] dst_vm,
    output logic            ok
);
    always_comb begin
        ok = (node_vm == src_vm) || (node_vm == dst_vm);
    end
endmodule

// File: rtl/rsv_sr_pick.sv
module rsv_sr_pick #(
    parameter int GRID_X = 16,
    localparam int XW    = $clog2(GRID_X),
    localparam int CW    = XW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRID_X-1:0] shared_cols,
    input  logic [XW-1:0]     src_x,
    input  logic [XW-1:0]     dst_x,
    output logic              found,
    output logic [XW-1:0]     col
);
    logic [GRID_X-1:0][CW-1:0] cost;

    for (genvar c = 0; c < GRID_X; c++) begin : g_cost
        logic [CW-1:0] ds, dd, cc, sx, dx;
        always_comb begin
            cc = CW'(c);
            sx = CW'(src_x);
            dx = CW'(dst_x);
            ds = (sx > cc) ? (sx - cc) : (cc - sx);
            dd = (dx > cc) ? (dx - cc) : (cc - dx);
            cost[c] = ds + dd;
        end
    end

    always_comb begin
        logic [CW-1:0] best;
        found = 1'b0;
        col   = '0;
        best  = '1;
        for (int c = 0; c < GRID_X; c++) begin
            if (shared_cols[c] && (!found || cost[c] < best)) begin
                found = 1'b1;
                col   = XW'(c);
                best  = cost[c];
            end
        end
    end

    // R6: a chosen column is always one marked shared
    p_pick_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> shared_cols[col]);
    // R7: nothing is found only when no column is shared
    p_pick_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (shared_cols == '0));
endmodule

// File: rtl/qos_route_sel.sv
module qos_route_sel
    import route_sel_pkg::*;
#(
    parameter int GRID_X = 16,
    parameter int GRID_Y = 16,
    parameter int VM_W   = 4,
    localparam int NODES = GRID_X * GRID_Y,
    localparam int NW    = $clog2(NODES),
    localparam int XW    = $clog2(GRID_X),
    localparam int YW    = $clog2(GRID_Y)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_col_sel,
    input  logic [NW-1:0]   cfg_addr,
    input  logic [VM_W-1:0] cfg_vm,
    input  logic            cfg_shared,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XW-1:0]   req_src_x,
    input  logic [YW-1:0]   req_src_y,
    input  logic [XW-1:0]   req_dst_x,
    input  logic [YW-1:0]   req_dst_y,
    input  logic [VM_W-1:0] req_vm,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [2:0]      rsp_kind,
    output logic [XW-1:0]   rsp_turn_x,
    output logic [YW-1:0]   rsp_turn_y,
    output logic            rsp_way_valid,
    output logic [XW-1:0]   rsp_way_x,
    output logic [YW-1:0]   rsp_way_y
);
    typedef struct packed {
        logic        valid;
        route_kind_e kind;
        logic [XW-1:0] tx;
        logic [YW-1:0] ty;
        logic        wv;
        logic [XW-1:0] wx;
        logic [YW-1:0] wy;
    } res_t;

    function automatic logic [NW-1:0] node_idx(input logic [XW-1:0] x, input logic [YW-1:0] y);
        return NW'(y) * NW'(GRID_X) + NW'(x);
    endfunction

    res_t s_d, s_q;
    logic [NW-1:0]     idx_xy, idx_yx, idx_dst;
    logic [VM_W-1:0]   vm_xy, vm_yx, vm_dst;
    logic [GRID_X-1:0] shared_cols;
    logic              xy_ok, yx_ok, sr_found;
    logic [XW-1:0]     sr_col;

    assign idx_xy  = node_idx(req_dst_x, req_src_y);
    assign idx_yx  = node_idx(req_src_x, req_dst_y);
    assign idx_dst = node_idx(req_dst_x, req_dst_y);

    rsv_vm_table #(.GRID_X(GRID_X), .GRID_Y(GRID_Y), .VM_W(VM_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .col_sel(cfg_col_sel),
        .addr(cfg_addr), .vm_in(cfg_vm), .shared_in(cfg_shared),
        .rd_a(idx_xy), .rd_b(idx_yx), .rd_c(idx_dst),
        .vm_a(vm_xy), .vm_b(vm_yx), .vm_c(vm_dst), .shared_cols(shared_cols)
    );

    rsv_turn_legal #(.VM_W(VM_W)) u_legal_xy (
        .node_vm(vm_xy), .src_vm(req_vm), .dst_vm(vm_dst), .ok(xy_ok));
    rsv_turn_legal #(.VM_W(VM_W)) u_legal_yx (
        .node_vm(vm_yx), .src_vm(req_vm), .dst_vm(vm_dst), .ok(yx_ok));

    rsv_sr_pick #(.GRID_X(GRID_X)) u_pick (
        .clk(clk), .rst_n(rst_n), .shared_cols(shared_cols),
        .src_x(req_src_x), .dst_x(req_dst_x), .found(sr_found), .col(sr_col));

    assign req_ready = !s_q.valid || rsp_ready;

    always_comb begin
        s_d = s_q;
        if (s_q.valid && rsp_ready) s_d.valid = 1'b0;
        if (req_valid && req_ready) begin
            s_d       = '0;
            s_d.valid = 1'b1;
            if ((req_src_x == req_dst_x) || (req_src_y == req_dst_y)) begin
                s_d.kind = RK_STRAIGHT;
            end else if (xy_ok) begin
                s_d.kind = RK_XY;
                s_d.tx   = req_dst_x;
                s_d.ty   = req_src_y;
            end else if (yx_ok) begin
                s_d.kind = RK_YX;
                s_d.tx   = req_src_x;
                s_d.ty   = req_dst_y;
            end else if (sr_found) begin
                s_d.kind = RK_DETOUR;
                s_d.wv   = 1'b1;
                s_d.wx   = sr_col;
                s_d.wy   = req_src_y;
                s_d.tx   = sr_col;
                s_d.ty   = req_dst_y;
            end else begin
                s_d.kind = RK_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid     = s_q.valid;
    assign rsp_kind      = s_q.kind;
    assign rsp_turn_x    = s_q.tx;
    assign rsp_turn_y    = s_q.ty;
    assign rsp_way_valid = s_q.wv;
    assign rsp_way_x     = s_q.wx;
    assign rsp_way_y     = s_q.wy;

    // R2: an accepted request yields a result on the next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R2: a stalled result keeps every field
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) &&
            $stable(rsp_turn_x) && $stable(rsp_turn_y) && $stable(rsp_way_valid) &&
            $stable(rsp_way_x) && $stable(rsp_way_y)));
    // R2: an empty output stage always accepts
    p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);
    // R6: a waypoint only accompanies a detour through a shared column
    p_way_detour_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_way_valid) |-> (rsp_kind == 3'd3 && shared_cols[rsp_way_x]));
endmodule

// File: tb/qos_route_sel_bench.sv
module qos_route_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GX = 16;
    localparam int GY = 16;
    localparam int NODES = GX * GY;

    logic clk, rst_n;
    logic cfg_we, cfg_col_sel, cfg_shared;
    logic [7:0] cfg_addr;
    logic [3:0] cfg_vm;
    logic req_valid, req_ready, rsp_valid, rsp_ready, rsp_way_valid;
    logic [3:0] req_src_x, req_src_y, req_dst_x, req_dst_y, req_vm;
    logic [2:0] rsp_kind;
    logic [3:0] rsp_turn_x, rsp_turn_y, rsp_way_x, rsp_way_y;

    qos_route_sel u_qos_route_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_col_sel(cfg_col_sel),
        .cfg_addr(cfg_addr), .cfg_vm(cfg_vm), .cfg_shared(cfg_shared),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src_x(req_src_x), .req_src_y(req_src_y),
        .req_dst_x(req_dst_x), .req_dst_y(req_dst_y), .req_vm(req_vm),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_turn_x(rsp_turn_x), .rsp_turn_y(rsp_turn_y),
        .rsp_way_valid(rsp_way_valid), .rsp_way_x(rsp_way_x), .rsp_way_y(rsp_way_y));

    int checks = 0, failures = 0, cycles = 0;
    bit chk_en = 0, done = 0;
    string phase = "";

    int vm_ref[NODES];
    bit sh_ref[GX];
    bit exp_valid = 0, acc_flag = 0, acc_now;
    int exp_k, exp_tx, exp_ty, exp_wv, exp_wx, exp_wy;

    initial clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s %s actual=%0d expected=%0d", tag, phase, what, act, exp);
        end
    endtask

    function automatic int iabs(input int a);
        return (a < 0) ? -a : a;
    endfunction

    // Behavioural model of the routing rules
    task automatic compute(input int sx, sy, dx, dy, v,
                           output int k, tx, ty, wv, wx, wy);
        int dv, best, bc;
        k = 0; tx = 0; ty = 0; wv = 0; wx = 0; wy = 0;
        dv = vm_ref[dy*GX+dx];
        if (sx == dx || sy == dy) begin
            k = 0;
        end else if (vm_ref[sy*GX+dx] == v || vm_ref[sy*GX+dx] == dv) begin
            k = 1; tx = dx; ty = sy;
        end else if (vm_ref[dy*GX+sx] == v || vm_ref[dy*GX+sx] == dv) begin
            k = 2; tx = sx; ty = dy;
        end else begin
            bc = -1; best = 0;
            for (int c = 0; c < GX; c++)
                if (sh_ref[c] && (bc < 0 || iabs(sx-c)+iabs(c-dx) < best)) begin
                    bc = c; best = iabs(sx-c)+iabs(c-dx);
                end
            if (bc < 0) k = 4;
            else begin k = 3; wv = 1; wx = bc; wy = sy; tx = bc; ty = dy; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 0; acc_flag <= 0;
            for (int i = 0; i < NODES; i++) vm_ref[i] = 0;
            for (int c = 0; c < GX; c++) sh_ref[c] = 0;
        end else begin
            int k, tx, ty, wv, wx, wy;
            acc_now = req_valid && (!exp_valid || rsp_ready);
            acc_flag <= acc_now;
            if (acc_now) begin
                compute(req_src_x, req_src_y, req_dst_x, req_dst_y, req_vm, k, tx, ty, wv, wx, wy);
                exp_valid <= 1; exp_k <= k; exp_tx <= tx; exp_ty <= ty;
                exp_wv <= wv; exp_wx <= wx; exp_wy <= wy;
            end else if (rsp_ready) exp_valid <= 0;
            if (cfg_we) begin
                if (cfg_col_sel) sh_ref[cfg_addr[3:0]] = cfg_shared;
                else vm_ref[cfg_addr] = cfg_vm;
            end
        end
    end

    // Per-cycle comparison, sampled after the edge has settled
    always begin
        @(posedge clk); #1;
        if (chk_en) begin
            string t;
            chk(rsp_valid == exp_valid, "R2", "rsp_valid", rsp_valid, exp_valid);
            chk(req_ready == (!exp_valid || rsp_ready), "R2", "req_ready", req_ready, !exp_valid || rsp_ready);
            if (exp_valid) begin
                case (exp_k)
                    0: t = "R3"; 1: t = "R4"; 2: t = "R5"; 3: t = "R6"; default: t = "R7";
                endcase
                chk(rsp_kind == exp_k, t, "kind", rsp_kind, exp_k);
                chk(rsp_turn_x == exp_tx, t, "turn_x", rsp_turn_x, exp_tx);
                chk(rsp_turn_y == exp_ty, t, "turn_y", rsp_turn_y, exp_ty);
                chk(rsp_way_valid == exp_wv, t, "way_valid", rsp_way_valid, exp_wv);
                chk(rsp_way_x == exp_wx, t, "way_x", rsp_way_x, exp_wx);
                chk(rsp_way_y == exp_wy, t, "way_y", rsp_way_y, exp_wy);
            end
        end
    end

    always @(negedge clk) rsp_ready <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL R2 watchdog actual=%0d expected=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr_node(input int x, y, v);
        @(negedge clk);
        cfg_we = 1; cfg_col_sel = 0; cfg_addr = 8'(y*GX+x); cfg_vm = 4'(v);
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic wr_col(input int c, input bit s);
        @(negedge clk);
        cfg_we = 1; cfg_col_sel = 1; cfg_addr = 8'(c); cfg_shared = s;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic send(input int sx, sy, dx, dy, v);
        @(negedge clk);
        req_src_x = 4'(sx); req_src_y = 4'(sy); req_dst_x = 4'(dx); req_dst_y = 4'(dy);
        req_vm = 4'(v); req_valid = 1;
        do @(negedge clk); while (!acc_flag);
        req_valid = 0;
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) begin
            int sx, sy, v;
            sx = $urandom % GX; sy = $urandom % GY;
            v = (($urandom % 4) != 0) ? vm_ref[sy*GX+sx] : ($urandom % 16);
            send(sx, sy, $urandom % GX, $urandom % GY, v);
        end
    endtask

    initial begin
        rst_n = 0; cfg_we = 0; cfg_col_sel = 0; cfg_addr = 0; cfg_vm = 0; cfg_shared = 0;
        req_valid = 0; req_src_x = 0; req_src_y = 0; req_dst_x = 0; req_dst_y = 0; req_vm = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        phase = "reset";
        chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
        chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
        chk_en = 1;

        // R1 table defaults: every node VM 0, so turns are legal
        phase = "defaults";
        send_rand(30);
        send(2, 3, 9, 11, 7);    // R4: turn (9,3) is VM 0 = destination VM
        send(5, 1, 5, 14, 3);    // R3: same column

        // R8: load a random VM map and two interior shared columns
        phase = "R8-map";
        for (int i = 0; i < NODES; i++) wr_node(i % GX, i / GX, $urandom % 16);
        wr_col(5, 1); wr_col(11, 1);
        send_rand(300);

        // R7: withdraw every shared column
        phase = "no-shared";
        wr_col(5, 0); wr_col(11, 0);
        send_rand(80);

        // R6 tie: shared columns at both edges, equal cost picks column 0
        phase = "edge-tie";
        wr_col(0, 1); wr_col(15, 1);
        wr_node(12, 2, 9); wr_node(3, 9, 9); wr_node(12, 9, 5);
        send(3, 2, 12, 9, 1);   // R6: both turns illegal, cost 15 each -> column 0
        send(12, 9, 3, 2, 1);   // R5/R6 reverse direction
        // R5: make Y-then-X legal only
        wr_node(3, 9, 1);
        send(3, 2, 12, 9, 1);
        send_rand(150);

        req_valid = 0;
        repeat (6) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule